// File: doc/BRIEF.md
# Status-Word Call Stack Controller

This block runs the subroutine return stack of a small microcontroller whose stack is kept in its internal data RAM. A 3-bit pointer sits in the low bits of the processor status word and picks one of eight two-byte slots. A call request saves the 12-bit return address and the upper status nibble into the current slot, then advances the pointer. There are two return variants, and both step the pointer back and fetch the saved address. The plain variant leaves the status word's upper nibble alone. The restoring variant also writes the saved nibble back into the status word.

The block owns the status word register and has a load port for it. It moves each stack entry over a byte-wide RAM port with synchronous reads, one byte per cycle. The RAM array and instruction decode are outside the block. While a transfer is in progress, `busy` is high and every new request is ignored.

Top module: `call_stack`

## Requirements
- R1: After reset the status word is 00h, `busy`, `ramWe` and `pcValid` are 0.
- R2: Slot k (k = status bits 2:0) uses RAM address 08h+2k for return-address bits 7:0 and address 09h+2k for a byte holding return-address bits 11:8 in bits 3:0 and status bits 7:4 in bits 7:4. All stack accesses fall in 08h..17h.
- R3: A call request taken when idle writes the low byte and then the high byte on the two following cycles, with `busy` high on exactly those two cycles. After the second write the pointer has advanced by one, wrapping 7 to 0.
- R4: A return request taken when idle first decrements the pointer (0 wraps to 7). It then reads the low byte and the high byte of that slot, with read data arriving one cycle after the address. `busy` is high for three cycles, and on the fourth cycle after the request `pcValid` is high for one cycle with the restored address on `pcOut`. A plain return (`popRestore`=0) leaves status bits 7:4 unchanged.
- R5: A return with `popRestore`=1 also loads status bits 7:4 from the stored nibble, in the same cycle that `pcOut` is updated.
- R6: Call, return and status-load requests made while `busy` is high are ignored. When call and return are requested together, only the call is performed.
- R7: `pswWe` loads all eight status bits from `pswWd` only when the block is idle and neither call nor return is requested. Otherwise the status word holds.
- R8: Status bit 3 is never changed by calls or returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushReq | input | 1 | Call request: save `pcIn` and the status nibble |
| popReq | input | 1 | Return request |
| popRestore | input | 1 | With `popReq`: also restore status bits 7:4 |
| pcIn | input | 12 | Return address to save on a call |
| pswWe | input | 1 | Load the status word from `pswWd` |
| pswWd | input | 8 | New status word value |
| psw | output | 8 | Status word; bits 2:0 are the stack pointer |
| busy | output | 1 | A stack transfer is in progress |
| pcOut | output | 12 | Address restored by the last return |
| pcValid | output | 1 | One-cycle pulse when `pcOut` is updated |
| ramAddr | output | 6 | RAM byte address |
| ramWe | output | 1 | RAM write enable |
| ramWdata | output | 8 | RAM write data |
| ramRdata | input | 8 | RAM read data, valid one cycle after the address |

## Verification
Taking the request edge as cycle 0, a call shows `busy` in cycles 1 and 2, and the advanced pointer and the written bytes are visible from cycle 3. For a return, the decremented pointer is visible in cycle 1, `busy` covers cycles 1 to 3, and `pcOut`, `pcValid` and any restored nibble appear in cycle 4. The bench holds each request for one edge and samples on falling edges at exactly these cycle offsets, so a result that lands one cycle early or late counts as a failure. It keeps its own model of the slots and of the status word to predict every value.

// File: rtl/call_stack_pkg.sv
package call_stack_pkg;

  typedef struct packed {
    logic capPush;   // latch return address and status nibble
    logic spInc;     // advance pointer
    logic spDec;     // step pointer back
    logic hiByte;    // address the high byte of the slot
    logic ramWe;     // write strobe to RAM
    logic capLo;     // latch low byte from RAM
    logic capHi;     // latch high byte, publish address
    logic restore;   // reload status nibble from RAM
    logic pswLoad;   // load whole status word
  } stackStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_HI,
    ST_RD_LO,
    ST_RD_HI,
    ST_RD_FIN
  } stackState_t;

endpackage

// File: rtl/call_stack_ctrl.sv
module call_stack_ctrl
  import call_stack_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushReq,
  input  logic          popReq,
  input  logic          popRestore,
  input  logic          pswWe,
  output stackStrobes_t strb,
  output logic          busy,
  output logic          pcValid
);

  stackState_t state, stateNext;
  logic restoreQ;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (pushReq) begin
          strb.capPush = 1'b1;
          stateNext    = ST_WR_LO;
        end else if (popReq) begin
          strb.spDec = 1'b1;
          stateNext  = ST_RD_LO;
        end else if (pswWe) begin
          strb.pswLoad = 1'b1;
        end
      end
      ST_WR_LO: begin
        strb.ramWe = 1'b1;
        stateNext  = ST_WR_HI;
      end
      ST_WR_HI: begin
        strb.ramWe  = 1'b1;
        strb.hiByte = 1'b1;
        strb.spInc  = 1'b1;
        stateNext   = ST_IDLE;
      end
      ST_RD_LO: begin
        stateNext = ST_RD_HI;
      end
      ST_RD_HI: begin
        strb.hiByte = 1'b1;
        strb.capLo  = 1'b1;
        stateNext   = ST_RD_FIN;
      end
      ST_RD_FIN: begin
        strb.capHi   = 1'b1;
        strb.restore = restoreQ;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      restoreQ <= 1'b0;
      pcValid  <= 1'b0;
    end else begin
      state   <= stateNext;
      pcValid <= (state == ST_RD_FIN);
      if (state == ST_IDLE && !pushReq && popReq)
        restoreQ <= popRestore;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/call_stack_dp.sv
module call_stack_dp
  import call_stack_pkg::*;
#(
  parameter int PC_W       = 12,
  parameter int RAM_AW     = 6,
  parameter int STACK_BASE = 8,
  parameter int SP_W       = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  stackStrobes_t     strb,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [7:0]        pswWd,
  input  logic [7:0]        ramRdata,
  output logic [7:0]        psw,
  output logic [PC_W-1:0]   pcOut,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [7:0]        ramWdata
);

  localparam int PC_HI_W = PC_W - 8;
  localparam int NIB_W   = 8 - PC_HI_W;

  logic [PC_W-1:0]  pcHold;
  logic [NIB_W-1:0] nibHold;
  logic [7:0]       loByte;
  logic [SP_W-1:0]  sp;

  assign sp       = psw[SP_W-1:0];
  assign ramAddr  = RAM_AW'(STACK_BASE) + RAM_AW'({sp, strb.hiByte});
  assign ramWdata = strb.hiByte ? {nibHold, pcHold[PC_W-1:8]} : pcHold[7:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psw     <= '0;
      pcHold  <= '0;
      nibHold <= '0;
      loByte  <= '0;
      pcOut   <= '0;
    end else begin
      if (strb.capPush) begin
        pcHold  <= pcIn;
        nibHold <= psw[7:8-NIB_W];
      end
      if (strb.pswLoad)
        psw <= pswWd;
      else if (strb.spInc)
        psw[SP_W-1:0] <= sp + SP_W'(1);
      else if (strb.spDec)
        psw[SP_W-1:0] <= sp - SP_W'(1);
      if (strb.capLo)
        loByte <= ramRdata;
      if (strb.capHi) begin
        pcOut <= {ramRdata[PC_HI_W-1:0], loByte};
        if (strb.restore)
          psw[7:8-NIB_W] <= ramRdata[7:PC_HI_W];
      end
    end
  end

endmodule

// File: rtl/call_stack.sv
module call_stack
  import call_stack_pkg::*;
#(
  parameter int PC_W       = 12,
  parameter int RAM_AW     = 6,
  parameter int STACK_BASE = 8,
  parameter int SP_W       = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              popRestore,
  input  logic [PC_W-1:0]   pcIn,
  input  logic              pswWe,
  input  logic [7:0]        pswWd,
  output logic [7:0]        psw,
  output logic              busy,
  output logic [PC_W-1:0]   pcOut,
  output logic              pcValid,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramWe,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata
);

  stackStrobes_t strb;

  call_stack_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pushReq    (pushReq),
    .popReq     (popReq),
    .popRestore (popRestore),
    .pswWe      (pswWe),
    .strb       (strb),
    .busy       (busy),
    .pcValid    (pcValid)
  );

  call_stack_dp #(
    .PC_W       (PC_W),
    .RAM_AW     (RAM_AW),
    .STACK_BASE (STACK_BASE),
    .SP_W       (SP_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pcIn     (pcIn),
    .pswWd    (pswWd),
    .ramRdata (ramRdata),
    .psw      (psw),
    .pcOut    (pcOut),
    .ramAddr  (ramAddr),
    .ramWdata (ramWdata)
  );

  assign ramWe = strb.ramWe;

endmodule

// File: rtl/call_stack_chk.sv
module call_stack_chk #(
  parameter int RAM_AW     = 6,
  parameter int STACK_BASE = 8,
  parameter int SP_W       = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushReq,
  input logic              popReq,
  input logic              pswWe,
  input logic              busy,
  input logic              ramWe,
  input logic [RAM_AW-1:0] ramAddr,
  input logic [7:0]        psw,
  input logic              pcValid
);

  localparam int LAST_ADDR = STACK_BASE + 2 * (1 << SP_W) - 1;

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> busy); // R3

  AST_ADDR_IN_REGION: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (ramAddr >= RAM_AW'(STACK_BASE) && ramAddr <= RAM_AW'(LAST_ADDR))); // R2

  AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(ramWe)) |-> (psw[SP_W-1:0] == $past(psw[SP_W-1:0]) + SP_W'(1))); // R3

  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    pcValid |-> ($past(busy) && !$past(ramWe) && !busy)); // R4

  AST_IDLE_PSW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && !$past(pushReq) && !$past(popReq) && !$past(pswWe))
      |-> $stable(psw)); // R7

  AST_BIT3_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> (psw[3] == $past(psw[3]))); // R8

endmodule

bind call_stack call_stack_chk #(
  .RAM_AW     (RAM_AW),
  .STACK_BASE (STACK_BASE),
  .SP_W       (SP_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pushReq (pushReq),
  .popReq  (popReq),
  .pswWe   (pswWe),
  .busy    (busy),
  .ramWe   (ramWe),
  .ramAddr (ramAddr),
  .psw     (psw),
  .pcValid (pcValid)
);

// File: tb/test_call_stack.sv
`timescale 1ns/1ps
module test_call_stack;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushReq = 1'b0, popReq = 1'b0, popRestore = 1'b0, pswWe = 1'b0;
  logic [11:0] pcIn = '0;
  logic [7:0]  pswWd = '0;
  logic [7:0]  psw;
  logic        busy, pcValid, ramWe;
  logic [11:0] pcOut;
  logic [5:0]  ramAddr;
  logic [7:0]  ramWdata, ramRdata;

  logic [7:0]  mem [64];
  int checks = 0, failures = 0;
  logic [2:0]  expSp;
  logic [7:0]  expPsw;
  logic [15:0] shadow [8];

  always #4 clk = ~clk;

  call_stack i_call_stack (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .popRestore(popRestore), .pcIn(pcIn), .pswWe(pswWe), .pswWd(pswWd),
    .psw(psw), .busy(busy), .pcOut(pcOut), .pcValid(pcValid),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  function automatic logic [7:0] initByte(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  initial for (int i = 0; i < 64; i++) mem[i] = initByte(i);

  always @(posedge clk) begin
    if (ramWe) mem[ramAddr] <= ramWdata;
    ramRdata <= mem[ramAddr];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadPsw(input logic [7:0] v);
    @(negedge clk); pswWe = 1'b1; pswWd = v;
    @(negedge clk); pswWe = 1'b0;
    expPsw = v; expSp = v[2:0];
    check("R7 status load", psw, expPsw);
  endtask

  task automatic doPush(input logic [11:0] pc);
    logic [2:0] slot;
    slot = expSp;
    @(negedge clk); pushReq = 1'b1; pcIn = pc;
    @(negedge clk); pushReq = 1'b0;
    check("R3 busy cycle 1", busy, 1'b1);
    @(negedge clk);
    check("R3 busy cycle 2", busy, 1'b1);
    @(negedge clk);
    check("R3 busy low after two writes", busy, 1'b0);
    expSp = slot + 3'd1;
    expPsw[2:0] = expSp;
    shadow[slot] = {expPsw[7:4], pc};
    check("R3 pointer advanced", psw, expPsw);
    check("R2 low byte in slot", mem[8 + 2 * slot], pc[7:0]);
    check("R2 high byte in slot", mem[9 + 2 * slot], {expPsw[7:4], pc[11:8]});
  endtask

  task automatic doPop(input logic restore);
    @(negedge clk); popReq = 1'b1; popRestore = restore;
    @(negedge clk); popReq = 1'b0; popRestore = 1'b0;
    expSp = expSp - 3'd1;
    expPsw[2:0] = expSp;
    check("R4 pointer stepped back", psw[2:0], expSp);
    check("R4 busy during read", busy, 1'b1);
    @(negedge clk);
    @(negedge clk);
    check("R4 busy in last read cycle", busy, 1'b1);
    check("R4 no early valid", pcValid, 1'b0);
    @(negedge clk);
    check("R4 valid on fourth cycle", pcValid, 1'b1);
    check("R4 restored address", pcOut, shadow[expSp][11:0]);
    if (restore) begin
      expPsw[7:4] = shadow[expSp][15:12];
      check("R5 status nibble restored", psw, expPsw);
    end else begin
      check("R4 status nibble kept", psw, expPsw);
    end
    @(negedge clk);
    check("R4 valid single pulse", pcValid, 1'b0);
  endtask

  // op: 0 load status, 1 call, 2 plain return, 3 restoring return
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 12'h0A8}, {2'd1, 12'h123}, {2'd0, 12'h059}, {2'd1, 12'hABC},
    {2'd0, 12'h032}, {2'd3, 12'h000}, {2'd2, 12'h000}, {2'd0, 12'h007},
    {2'd1, 12'h7FE}, {2'd2, 12'h000}, {2'd1, 12'hF01}, {2'd3, 12'h000}
  };

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) shadow[i] = {initByte(9 + 2 * i), initByte(8 + 2 * i)};
    expSp = '0; expPsw = '0;
    repeat (3) @(negedge clk);
    check("R1 status after reset", psw, 8'h00);
    check("R1 busy after reset", busy, 1'b0);
    check("R1 write after reset", ramWe, 1'b0);
    check("R1 valid after reset", pcValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // pop from empty pointer wraps to slot 7 (R4)
    doPop(1'b0);
    check("R4 wrap 0 to 7", psw[2:0], 3'd7);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][13:12])
        2'd0: loadPsw(VEC[i][7:0]);
        2'd1: doPush(VEC[i][11:0]);
        2'd2: doPop(1'b0);
        default: doPop(1'b1);
      endcase
    end

    // push from slot 7 wraps to 0 (R3)
    loadPsw(8'h5F);
    doPush(12'h2C4);
    check("R3 wrap 7 to 0", psw[2:0], 3'd0);

    // requests during busy are ignored (R6, R7)
    @(negedge clk); pushReq = 1'b1; pcIn = 12'h456;
    @(negedge clk); pcIn = 12'h999; popReq = 1'b1; pswWe = 1'b1; pswWd = 8'hF3;
    @(negedge clk); pushReq = 1'b0; popReq = 1'b0; pswWe = 1'b0;
    @(negedge clk);
    check("R6 single push under busy requests", psw, {4'h5, 4'hF & 4'h8 | 4'h1});
    check("R6 first address kept", mem[8], 8'h56);
    check("R6 high byte kept", mem[9], 8'h54);
    shadow[0] = 16'h5456;
    expSp = 3'd1; expPsw = 8'h59;

    // call and return together: only the call happens; status load also ignored (R6, R7)
    @(negedge clk); pushReq = 1'b1; popReq = 1'b1; pswWe = 1'b1; pswWd = 8'h00; pcIn = 12'h3A5;
    @(negedge clk); pushReq = 1'b0; popReq = 1'b0; pswWe = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R6 push wins over pop", psw, 8'h5A);
    check("R7 load ignored with request", psw[7:3], 5'b01011);
    check("R2 slot 1 low byte", mem[10], 8'hA5);
    shadow[1] = 16'h53A5;
    expSp = 3'd2; expPsw = 8'h5A;

    // bit 3 survives restoring return (R8)
    loadPsw(8'h0A);
    doPop(1'b1);
    check("R8 bit 3 untouched", psw[3], 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule